// File: doc/BRIEF.md
# Transport Stream Packet Length Checker

The block sits between a byte-serial transport stream input and a downstream receive FIFO. Each byte arrives with a valid strobe. Two markers frame the packet: one flags its first byte and one flags its last byte. The block compares the length of each packet with a nominal length chosen by software, either 188 or 192 bytes.

The FIFO holds packet data on a speculative write pointer. The block writes bytes as they arrive and decides only at the last byte whether the packet stays or goes. A commit pulse publishes every byte written since the previous decision. An abort pulse rewinds the FIFO to the last committed point. A correct-length packet is committed whole. A long packet is committed after its first nominal-length bytes, and the rest of its bytes are never written. A short packet is aborted. A packet that meets a full FIFO is aborted, and packets committed before it are kept.

Three saturating counters and four sticky status flags record these outcomes. The flags are cleared by writing 1. A fourth flag records that the external time stamp counter wrapped after a packet ended. A small register port gives access to the control bit, the flags, the interrupt enables and the counters. An interrupt line is high while any enabled flag is set.

Top module: `ts_len_check`

## Requirements
- R1: CTRL (address 0) bit 0 selects the nominal length: 0 gives 188 bytes, 1 gives 192 bytes. CTRL reads back only bit 0, and all its other bits read 0.
- R2: A packet of exactly the nominal length is written to the FIFO in full, in order, and committed in the cycle of its last write. Only the packet counter (address 3) increments, and no status flag is set.
- R3: A longer packet writes only its first nominal-length bytes and is then committed. The packet counter and the long counter (address 4) each increment by one, and status bit 0 is set.
- R4: A shorter packet is aborted and adds nothing to the committed data. The short counter (address 5) increments by one, status bit 1 is set, and the packet counter does not change.
- R5: If fifo_full is high while a byte that would be written is presented, that byte and the rest of the packet are not written. The packet is aborted and status bit 2 is set. The packet and long counters do not change, and data committed earlier stays intact.
- R6: Status bit 3 is set by the first ts_wrap pulse that follows the end of a packet. A ts_wrap pulse with no packet end since the previous hit, or before any packet, sets nothing.
- R7: The status register (address 1) resets to 0. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and bits 15:4 read 0.
- R8: The three counters are 16 bits wide, reset to 0, and stick at 0xFFFF instead of wrapping.
- R9: irq is high exactly when a status bit and the matching bit of the enable register (address 2) are both 1.
- R10: Bytes with in_valid high that arrive outside a packet, before any start marker, are ignored. They cause no write, no commit, no abort and no counter change.
- R11: After reset, fifo_wr, fifo_commit, fifo_abort and irq are 0, and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_eop | input | 1 | Input byte is the last of a packet |
| in_data | input | 8 | Input byte |
| fifo_full | input | 1 | Downstream FIFO cannot take a byte this cycle |
| fifo_wr | output | 1 | Speculative FIFO write strobe |
| fifo_data | output | 8 | FIFO write data |
| fifo_commit | output | 1 | Publish all bytes written since the last commit or abort |
| fifo_abort | output | 1 | Discard all bytes written since the last commit or abort |
| ts_wrap | input | 1 | One-cycle pulse when the time stamp counter wraps |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
A wrong byte count or a wrong length class shows on the FIFO side in the cycle after the last byte. Either the commit and abort pulses disagree with the packet length, or the number of bytes committed differs from the nominal length. The counters and flags update at the same edge, so one register read right after the packet exposes a wrong classification. A stuck overflow or arming bit carries over to the next packet and shows as an extra abort or a spurious wrap flag on the following check. A bad saturation stage shows only when the counter reaches its top, so the bench drives a counter past 0xFFFF on purpose.

// File: rtl/ts_pkg.sv
package ts_pkg;
    localparam int ADDR_W = 3;
    localparam int NFLAG  = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_IEN   = 3'd2;
    localparam logic [ADDR_W-1:0] A_PKT   = 3'd3;
    localparam logic [ADDR_W-1:0] A_LONG  = 3'd4;
    localparam logic [ADDR_W-1:0] A_SHORT = 3'd5;

    localparam int B_LONG  = 0;
    localparam int B_SHORT = 1;
    localparam int B_OVF   = 2;
    localparam int B_WRAP  = 3;

    // Per-packet outcome, valid for one cycle at the last byte
    typedef struct packed {
        logic good;
        logic long_pkt;
        logic short_pkt;
        logic ovf;
        logic ended;
    } ev_t;
endpackage

// File: rtl/ts_frame_ctl.sv
module ts_frame_ctl
    import ts_pkg::*;
#(
    parameter int LEN_A = 188,
    parameter int LEN_B = 192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       len_sel,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic       in_eop,
    input  logic [7:0] in_data,
    input  logic       fifo_full,
    output logic       fifo_wr,
    output logic [7:0] fifo_data,
    output logic       fifo_commit,
    output logic       fifo_abort,
    output ev_t        ev
);
    localparam int LEN_MAX = (LEN_A > LEN_B) ? LEN_A : LEN_B;
    localparam int CW      = $clog2(LEN_MAX + 2);
    localparam logic [CW-1:0] NOM_A   = CW'(LEN_A);
    localparam logic [CW-1:0] NOM_B   = CW'(LEN_B);
    localparam logic [CW-1:0] CNT_TOP = CW'(LEN_MAX + 1);

    typedef struct packed {
        logic          in_pkt;
        logic [CW-1:0] cnt;
        logic          ovf;
        logic          wr;
        logic [7:0]    data;
        logic          commit;
        logic          abort;
    } st_t;

    st_t st_d, st_q;

    logic [CW-1:0] nom;
    logic [CW-1:0] idx;
    logic          take, first, ovf_acc, need;

    always_comb begin
        st_d        = st_q;
        st_d.wr     = 1'b0;
        st_d.commit = 1'b0;
        st_d.abort  = 1'b0;
        ev          = '0;

        nom     = len_sel ? NOM_B : NOM_A;
        take    = in_valid & (st_q.in_pkt | in_sop);
        first   = in_sop & ~st_q.in_pkt;
        idx     = first ? '0 : st_q.cnt;
        ovf_acc = first ? 1'b0 : st_q.ovf;
        need    = (idx < nom);

        if (take) begin
            st_d.in_pkt = 1'b1;
            st_d.cnt    = (idx == CNT_TOP) ? idx : idx + 1'b1;
            st_d.ovf    = ovf_acc | (need & fifo_full);
            st_d.wr     = need & ~fifo_full & ~ovf_acc;
            st_d.data   = in_data;
            if (in_eop) begin
                st_d.in_pkt  = 1'b0;
                ev.ended     = 1'b1;
                ev.ovf       = st_d.ovf;
                ev.short_pkt = (st_d.cnt < nom);
                ev.good      = ~ev.short_pkt & ~st_d.ovf;
                ev.long_pkt  = ev.good & (st_d.cnt > nom);
                st_d.commit  = ev.good;
                st_d.abort   = ~ev.good;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fifo_wr     = st_q.wr;
    assign fifo_data   = st_q.data;
    assign fifo_commit = st_q.commit;
    assign fifo_abort  = st_q.abort;
endmodule

// File: rtl/ts_stamp_watch.sv
module ts_stamp_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_end,
    input  logic ts_wrap,
    output logic hit
);
    typedef struct packed {
        logic armed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = ts_wrap & st_q.armed;
        if (pkt_end)  st_d.armed = 1'b1;
        else if (hit) st_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ts_stat_regs.sv
module ts_stat_regs
    import ts_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ev_t               ev,
    input  logic              wrap_hit,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              len_sel,
    output logic [NFLAG-1:0]  status,
    output logic [NFLAG-1:0]  ien,
    output logic [REG_W-1:0]  pkt_cnt,
    output logic [REG_W-1:0]  short_cnt,
    output logic              irq
);
    localparam logic [REG_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             ctrl;
        logic [NFLAG-1:0] stat;
        logic [NFLAG-1:0] ien;
        logic [REG_W-1:0] pkt;
        logic [REG_W-1:0] lng;
        logic [REG_W-1:0] sht;
    } st_t;

    st_t st_d, st_q;
    logic [NFLAG-1:0] set_vec;

    always_comb begin
        st_d = st_q;

        set_vec          = '0;
        set_vec[B_LONG]  = ev.long_pkt;
        set_vec[B_SHORT] = ev.short_pkt;
        set_vec[B_OVF]   = ev.ovf;
        set_vec[B_WRAP]  = wrap_hit;

        if (reg_wr) begin
            unique case (reg_addr)
                A_CTRL:  st_d.ctrl = reg_wdata[0];
                A_STAT:  st_d.stat = st_q.stat & ~reg_wdata[NFLAG-1:0];
                A_IEN:   st_d.ien  = reg_wdata[NFLAG-1:0];
                default: ;
            endcase
        end
        st_d.stat = st_d.stat | set_vec;

        if (ev.good && st_q.pkt != CNT_MAX)      st_d.pkt = st_q.pkt + 1'b1;
        if (ev.long_pkt && st_q.lng != CNT_MAX)  st_d.lng = st_q.lng + 1'b1;
        if (ev.short_pkt && st_q.sht != CNT_MAX) st_d.sht = st_q.sht + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:  reg_rdata[0]         = st_q.ctrl;
            A_STAT:  reg_rdata[NFLAG-1:0] = st_q.stat;
            A_IEN:   reg_rdata[NFLAG-1:0] = st_q.ien;
            A_PKT:   reg_rdata            = st_q.pkt;
            A_LONG:  reg_rdata            = st_q.lng;
            A_SHORT: reg_rdata            = st_q.sht;
            default: reg_rdata            = '0;
        endcase
    end

    assign len_sel   = st_q.ctrl;
    assign status    = st_q.stat;
    assign ien       = st_q.ien;
    assign pkt_cnt   = st_q.pkt;
    assign short_cnt = st_q.sht;
    assign irq       = |(st_q.stat & st_q.ien);
endmodule

// File: rtl/ts_len_check.sv
module ts_len_check
    import ts_pkg::*;
#(
    parameter int LEN_A = 188,
    parameter int LEN_B = 192,
    parameter int REG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [7:0]        in_data,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [7:0]        fifo_data,
    output logic              fifo_commit,
    output logic              fifo_abort,
    input  logic              ts_wrap,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    ev_t              ev;
    logic             len_sel;
    logic             wrap_hit;
    logic [NFLAG-1:0] status;
    logic [NFLAG-1:0] ien;
    logic [REG_W-1:0] pkt_cnt;
    logic [REG_W-1:0] short_cnt;

    ts_frame_ctl #(.LEN_A(LEN_A), .LEN_B(LEN_B)) i_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .len_sel     (len_sel),
        .in_valid    (in_valid),
        .in_sop      (in_sop),
        .in_eop      (in_eop),
        .in_data     (in_data),
        .fifo_full   (fifo_full),
        .fifo_wr     (fifo_wr),
        .fifo_data   (fifo_data),
        .fifo_commit (fifo_commit),
        .fifo_abort  (fifo_abort),
        .ev          (ev)
    );

    ts_stamp_watch i_stamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .pkt_end (ev.ended),
        .ts_wrap (ts_wrap),
        .hit     (wrap_hit)
    );

    ts_stat_regs #(.REG_W(REG_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .wrap_hit  (wrap_hit),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .len_sel   (len_sel),
        .status    (status),
        .ien       (ien),
        .pkt_cnt   (pkt_cnt),
        .short_cnt (short_cnt),
        .irq       (irq)
    );
endmodule

// File: rtl/ts_len_check_chk.sv
module ts_len_check_chk
    import ts_pkg::*;
#(
    parameter int LEN_A = 188,
    parameter int LEN_B = 192,
    parameter int REG_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_full,
    input logic              fifo_wr,
    input logic              fifo_commit,
    input logic              fifo_abort,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [NFLAG-1:0]  status,
    input logic [REG_W-1:0]  pkt_cnt,
    input logic [REG_W-1:0]  short_cnt
);
    localparam int LEN_MAX = (LEN_A > LEN_B) ? LEN_A : LEN_B;
    localparam int WC_W    = $clog2(LEN_MAX + 2);

    // Count FIFO writes since the last commit or abort
    logic [WC_W-1:0] wcnt_q;
    logic [WC_W-1:0] wcnt_cur;
    assign wcnt_cur = wcnt_q + WC_W'(fifo_wr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         wcnt_q <= '0;
        else if (fifo_commit || fifo_abort) wcnt_q <= '0;
        else                                wcnt_q <= wcnt_cur;
    end

    a_r2_commit_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_commit && fifo_abort));

    a_r3_write_limit: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt_cur <= WC_W'(LEN_MAX));

    a_r5_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |=> !fifo_wr);

    a_r8_pkt_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_cnt != '0) |=> (pkt_cnt != '0));

    a_r8_short_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (short_cnt != '0) |=> (short_cnt != '0));

    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        a_r7_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status[k]) |-> $past(reg_wr && reg_addr == A_STAT && reg_wdata[k]));
    end
endmodule

bind ts_len_check ts_len_check_chk #(.LEN_A(LEN_A), .LEN_B(LEN_B), .REG_W(REG_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_full   (fifo_full),
    .fifo_wr     (fifo_wr),
    .fifo_commit (fifo_commit),
    .fifo_abort  (fifo_abort),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .status      (status),
    .pkt_cnt     (pkt_cnt),
    .short_cnt   (short_cnt)
);

// File: tb/test_ts_len_check.sv
module test_ts_len_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_data = '0;
    logic        fifo_full = 1'b0;
    logic        fifo_wr, fifo_commit, fifo_abort;
    logic [7:0]  fifo_data;
    logic        ts_wrap = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_checks = 0, n_fail = 0;
    int pend = 0, committed = 0, n_commit = 0, n_abort = 0, total_wr = 0;
    logic [7:0] last_data = '0;

    always #2 clk = ~clk;

    ts_len_check i_ts_len_check (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .fifo_full(fifo_full),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_commit(fifo_commit),
        .fifo_abort(fifo_abort), .ts_wrap(ts_wrap), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // FIFO model: speculative writes, published on commit, dropped on abort
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_wr) begin
                pend++;
                total_wr++;
                last_data = fifo_data;
            end
            if (fifo_commit) begin
                committed += pend;
                pend = 0;
                n_commit++;
            end
            if (fifo_abort) begin
                pend = 0;
                n_abort++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic send_pkt(input int len, input int full_at);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_sop    = (i == 0);
            in_eop    = (i == len - 1);
            in_data   = 8'(i);
            fifo_full = (i == full_at);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; fifo_full = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_wrap();
        @(negedge clk);
        ts_wrap = 1'b1;
        @(negedge clk);
        ts_wrap = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        chk("R11 fifo_wr", int'(fifo_wr), 0);
        chk("R11 commit", int'(fifo_commit), 0);
        chk("R11 abort", int'(fifo_abort), 0);
        chk("R11 irq", int'(irq), 0);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk($sformatf("R11 reg %0d", a), v, 0);
        end
    endtask

    task automatic t_wrap_idle();
        int v;
        pulse_wrap();
        rd(3'd1, v);
        chk("R6 wrap before any packet", v, 0);
    endtask

    task automatic t_good188();
        int v, c0;
        c0 = committed;
        send_pkt(188, -1);
        chk("R2 committed bytes", committed - c0, 188);
        chk("R2 last byte", int'(last_data), 187);
        rd(3'd3, v); chk("R2 pkt_cnt", v, 1);
        rd(3'd4, v); chk("R2 long_cnt", v, 0);
        rd(3'd1, v); chk("R2 status", v, 0);
    endtask

    task automatic t_long();
        int v, c0;
        c0 = committed;
        send_pkt(200, -1);
        chk("R3 committed bytes", committed - c0, 188);
        chk("R3 last byte", int'(last_data), 187);
        rd(3'd3, v); chk("R3 pkt_cnt", v, 2);
        rd(3'd4, v); chk("R3 long_cnt", v, 1);
        rd(3'd1, v); chk("R3 status", v, 1);
    endtask

    task automatic t_short();
        int v, c0, a0;
        c0 = committed; a0 = n_abort;
        send_pkt(100, -1);
        chk("R4 aborts", n_abort - a0, 1);
        chk("R4 committed unchanged", committed - c0, 0);
        rd(3'd5, v); chk("R4 short_cnt", v, 1);
        rd(3'd3, v); chk("R4 pkt_cnt", v, 2);
        rd(3'd1, v); chk("R4 status", v, 3);
    endtask

    task automatic t_mode192();
        int v, c0;
        wr(3'd0, 16'h0001);
        rd(3'd0, v); chk("R1 ctrl readback", v, 1);
        c0 = committed;
        send_pkt(192, -1);
        chk("R1 192 committed", committed - c0, 192);
        chk("R1 192 last byte", int'(last_data), 191);
        rd(3'd3, v); chk("R1 pkt_cnt", v, 3);
        c0 = committed;
        send_pkt(190, -1);
        chk("R1 190 dropped", committed - c0, 0);
        rd(3'd5, v); chk("R1 short_cnt", v, 2);
        c0 = committed;
        send_pkt(195, -1);
        chk("R1 195 truncated", committed - c0, 192);
        rd(3'd4, v); chk("R1 long_cnt", v, 2);
        rd(3'd3, v); chk("R1 pkt_cnt after long", v, 4);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_overflow();
        int v, c0, a0;
        c0 = committed; a0 = n_abort;
        send_pkt(188, 50);
        chk("R5 aborted", n_abort - a0, 1);
        chk("R5 committed unchanged", committed - c0, 0);
        rd(3'd1, v); chk("R5 ovf flag", (v >> 2) & 1, 1);
        rd(3'd3, v); chk("R5 pkt_cnt", v, 4);
        c0 = committed;
        send_pkt(188, -1);
        chk("R5 next packet committed", committed - c0, 188);
        rd(3'd3, v); chk("R5 pkt_cnt after good", v, 5);
    endtask

    task automatic t_stray();
        int v, w0, m0, a0;
        w0 = total_wr; m0 = n_commit; a0 = n_abort;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'hA5; in_eop = (i == 4);
        end
        @(negedge clk); in_valid = 1'b0; in_eop = 1'b0;
        @(negedge clk);
        chk("R10 no write", total_wr - w0, 0);
        chk("R10 no commit/abort", (n_commit - m0) + (n_abort - a0), 0);
        rd(3'd3, v); chk("R10 pkt_cnt", v, 5);
        rd(3'd5, v); chk("R10 short_cnt", v, 2);
    endtask

    task automatic t_w1c();
        int v;
        rd(3'd1, v); chk("R7 status before", v, 7);
        wr(3'd1, 16'h0000);
        rd(3'd1, v); chk("R7 write 0 no effect", v, 7);
        wr(3'd1, 16'h0001);
        rd(3'd1, v); chk("R7 clear long only", v, 6);
        wr(3'd1, 16'hFFFF);
        rd(3'd1, v); chk("R7 clear all, reserved 0", v, 0);
        wr(3'd0, 16'hFFFF);
        rd(3'd0, v); chk("R1 ctrl reserved bits", v, 1);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_irq();
        int v;
        wr(3'd2, 16'h0002);
        rd(3'd2, v); chk("R9 enable readback", v, 2);
        chk("R9 irq low, no flag", int'(irq), 0);
        send_pkt(10, -1);
        chk("R9 irq on short", int'(irq), 1);
        wr(3'd1, 16'h0002);
        #1; chk("R9 irq after clear", int'(irq), 0);
    endtask

    task automatic t_wrap();
        int v;
        pulse_wrap();
        rd(3'd1, v); chk("R6 wrap after packet", v, 8);
        wr(3'd1, 16'h0008);
        pulse_wrap();
        rd(3'd1, v); chk("R6 second wrap, no packet", v, 0);
    endtask

    task automatic t_saturate();
        int v;
        for (int i = 0; i < 65540; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = 8'h47;
        end
        @(negedge clk); in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        @(negedge clk);
        rd(3'd5, v); chk("R8 short_cnt saturated", v, 16'hFFFF);
        rd(3'd3, v); chk("R8 pkt_cnt untouched", v, 5);
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wrap_idle();
        t_good188();
        t_long();
        t_short();
        t_mode192();
        t_overflow();
        t_stray();
        t_w1c();
        t_irq();
        t_wrap();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule